// File: doc/BRIEF.md
# Round-Iterative 64-bit Block Encryptor with 80-bit Key

This block encrypts one 64-bit plaintext block under an 80-bit key using a substitution-permutation cipher of 31 rounds. Every clock cycle it executes one complete round. In the same cycle, the key schedule derives the next round key from an 80-bit key register. A round mixes the round key into the state by XOR, then passes each nibble through a fixed 4-bit substitution box, then moves every bit to a new position with a fixed permutation. After the last round, one more key XOR produces the ciphertext, which is written to an output register.

The block is used as a core inside a larger design. The caller presents the plaintext and key on parallel buses and pulses `start` while the core is idle. The core captures both buses on that edge. The inputs are free to change from then on. Thirty-two rising edges later the ciphertext register updates and `done` rises for one cycle. A small three-phase controller (idle, running, finishing) sequences the work. It ignores `start` while a block is in progress.

Top module: `lwc_enc80`

## Requirements
- R1: The output for plaintext 0 and key 0 is 5579C1387B228445 (hex). In general the output equals 31 rounds followed by a final XOR with round key 32. A round is: XOR the round key, substitute every nibble, permute the bits.
- R2: The substitution box maps nibble values 0 through F (hex) to C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2. Nibble j of the state is bits 4j+3..4j.
- R3: The permutation sends state bit i to bit position (16*i) mod 63 for i = 0..62. Bit 63 keeps its position.
- R4: The round key is bits 79:16 of the key register. After each round the register is updated in three steps. First it is rotated left by 61 bits. Then bits 79:76 pass through the substitution box. Finally bits 19:15 are XORed with the 5-bit round number, which counts 1 to 31.
- R5: `ct` and `done` update on the 32nd rising edge after the edge that accepts `start`, giving 33 cycles counting the start cycle.
- R6: `done` is high for exactly one cycle per completed block.
- R7: `ct` holds its value between completions.
- R8: A `start` pulse while a block is in progress is ignored. The running block completes with its own result and its own timing.
- R9: `pt` and `key` are sampled only on the accepting edge. Changing them afterwards does not affect the result.
- R10: Synchronous active-high `rst` clears `ct` and `done` and returns the core to idle. A block in progress when `rst` is applied is abandoned: it never raises `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin a block, taken only when idle |
| pt | input | 64 | Plaintext block |
| key | input | 80 | Cipher key |
| ct | output | 64 | Registered ciphertext |
| done | output | 1 | One-cycle pulse marking a ciphertext update |

## Verification
The hardest situations to reach from the ports involve a second event arriving while a block is in flight. One is a second `start` pulse. The other is a reset that cuts a block short. The other is changing `pt` and `key` right after acceptance. The bench raises `start` with different operands several rounds into a run. It then checks that the first block's ciphertext appears exactly 32 edges after its own start. It also scrambles the input buses immediately after every accepted start. Separately, it resets the core mid-run and watches well beyond the normal latency to confirm that no `done` appears and `ct` stays cleared.

// File: rtl/lwc_pkg.sv
`timescale 1ns/1ps
package lwc_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_FIN  = 2'd2
  } phase_t;

  function automatic logic [3:0] sub4(input logic [3:0] x);
    logic [3:0] y;
    case (x)
      4'h0: y = 4'hC;
      4'h1: y = 4'h5;
      4'h2: y = 4'h6;
      4'h3: y = 4'hB;
      4'h4: y = 4'h9;
      4'h5: y = 4'h0;
      4'h6: y = 4'hA;
      4'h7: y = 4'hD;
      4'h8: y = 4'h3;
      4'h9: y = 4'hE;
      4'hA: y = 4'hF;
      4'hB: y = 4'h8;
      4'hC: y = 4'h4;
      4'hD: y = 4'h7;
      4'hE: y = 4'h1;
      default: y = 4'h2;
    endcase
    return y;
  endfunction

endpackage

// File: rtl/lwc_round.sv
`timescale 1ns/1ps
module lwc_round #(
  parameter int BLOCK_W = 64
) (
  input  logic [BLOCK_W-1:0] st_in,
  input  logic [BLOCK_W-1:0] rkey,
  output logic [BLOCK_W-1:0] st_out
);
  import lwc_pkg::*;

  localparam int NIB    = BLOCK_W / 4;
  localparam int STRIDE = BLOCK_W / 4;
  localparam int MODV   = BLOCK_W - 1;

  logic [BLOCK_W-1:0] mixed;
  logic [BLOCK_W-1:0] subd;

  assign mixed = st_in ^ rkey;

  // nibble substitution, one box per nibble
  for (genvar j = 0; j < NIB; j++) begin : g_sub
    assign subd[4*j +: 4] = sub4(mixed[4*j +: 4]);
  end

  // bit scatter: bit i goes to (STRIDE*i) mod (BLOCK_W-1); top bit stays
  for (genvar i = 0; i < BLOCK_W - 1; i++) begin : g_perm
    assign st_out[(i * STRIDE) % MODV] = subd[i];
  end
  assign st_out[BLOCK_W-1] = subd[BLOCK_W-1];

endmodule

// File: rtl/lwc_keysched.sv
`timescale 1ns/1ps
module lwc_keysched #(
  parameter int KEY_W   = 80,
  parameter int ROT     = 61,
  parameter int CNT_W   = 5,
  parameter int CNT_LSB = 15
) (
  input  logic [KEY_W-1:0] kin,
  input  logic [CNT_W-1:0] rnd,
  output logic [KEY_W-1:0] kout
);
  import lwc_pkg::*;

  localparam int SPLIT = KEY_W - ROT;

  logic [KEY_W-1:0] rot;
  logic [KEY_W-1:0] boxed;

  // left rotation by ROT
  assign rot = {kin[SPLIT-1:0], kin[KEY_W-1:SPLIT]};

  always_comb begin
    boxed = rot;
    boxed[KEY_W-1 -: 4] = sub4(rot[KEY_W-1 -: 4]);
  end

  always_comb begin
    kout = boxed;
    kout[CNT_LSB +: CNT_W] = boxed[CNT_LSB +: CNT_W] ^ rnd;
  end

endmodule

// File: rtl/lwc_ctrl.sv
`timescale 1ns/1ps
module lwc_ctrl #(
  parameter int ROUNDS = 31,
  parameter int CNT_W  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output lwc_pkg::phase_t  phase,
  output logic [CNT_W-1:0] rnd,
  output logic             load,
  output logic             step,
  output logic             fin
);
  import lwc_pkg::*;

  localparam logic [CNT_W-1:0] LAST = CNT_W'(ROUNDS);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      rnd   <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          phase <= PH_RUN;
          rnd   <= CNT_W'(1);
        end
        PH_RUN: begin
          rnd <= rnd + CNT_W'(1);
          if (rnd == LAST) phase <= PH_FIN;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign load = (phase == PH_IDLE) && start;
  assign step = (phase == PH_RUN);
  assign fin  = (phase == PH_FIN);

endmodule

// File: rtl/lwc_enc80.sv
`timescale 1ns/1ps
module lwc_enc80 #(
  parameter int BLOCK_W = 64,
  parameter int KEY_W   = 80,
  parameter int ROUNDS  = 31,
  parameter int ROT     = 61,
  parameter int CNT_LSB = 15
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [BLOCK_W-1:0] pt,
  input  logic [KEY_W-1:0]   key,
  output logic [BLOCK_W-1:0] ct,
  output logic               done
);
  import lwc_pkg::*;

  localparam int CNT_W = $clog2(ROUNDS + 1);

  phase_t             phase;
  logic [CNT_W-1:0]   rnd;
  logic               load, step, fin;
  logic [BLOCK_W-1:0] st_q, st_d;
  logic [KEY_W-1:0]   kr_q, kr_d;
  logic [BLOCK_W-1:0] rkey;

  assign rkey = kr_q[KEY_W-1 -: BLOCK_W];

  lwc_ctrl #(.ROUNDS(ROUNDS), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .phase(phase), .rnd(rnd), .load(load), .step(step), .fin(fin)
  );

  lwc_round #(.BLOCK_W(BLOCK_W)) u_round (
    .st_in(st_q), .rkey(rkey), .st_out(st_d)
  );

  lwc_keysched #(.KEY_W(KEY_W), .ROT(ROT), .CNT_W(CNT_W), .CNT_LSB(CNT_LSB)) u_ks (
    .kin(kr_q), .rnd(rnd), .kout(kr_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= '0;
      kr_q <= '0;
      ct   <= '0;
      done <= 1'b0;
    end else begin
      done <= fin;
      if (load) begin
        st_q <= pt;
        kr_q <= key;
      end else if (step) begin
        st_q <= st_d;
        kr_q <= kr_d;
      end
      if (fin) ct <= st_q ^ rkey;
    end
  end

endmodule

// File: rtl/lwc_enc80_chk.sv
`timescale 1ns/1ps
module lwc_enc80_chk #(
  parameter int BLOCK_W = 64,
  parameter int ROUNDS  = 31,
  parameter int CNT_W   = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic [1:0]         phase,
  input logic [CNT_W-1:0]   rnd,
  input logic [BLOCK_W-1:0] ct,
  input logic               done
);
  localparam int LAT = ROUNDS + 2;

  logic [7:0] cyc;
  logic       accept;

  assign accept = (phase == 2'd0) && start;

  always_ff @(posedge clk) begin
    if (rst)                cyc <= '0;
    else if (accept)        cyc <= 8'd1;
    else if (done)          cyc <= '0;
    else if (cyc != 8'd0)   cyc <= cyc + 8'd1;
  end

  a_r5_latency: assert property (@(posedge clk) disable iff (rst)
    done |-> (cyc == 8'(LAT)));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r7_ct_hold: assert property (@(posedge clk) disable iff (rst)
    (!done && !$past(rst)) |-> $stable(ct));

  a_r8_no_restart: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd1) |=> ((phase == 2'd1 && rnd == $past(rnd) + CNT_W'(1)) ||
                         (phase == 2'd2 && $past(rnd) == CNT_W'(ROUNDS))));

  a_r9_accept: assert property (@(posedge clk) disable iff (rst)
    accept |=> (phase == 2'd1 && rnd == CNT_W'(1)));

  a_r10_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!done && ct == '0 && phase == 2'd0));

endmodule

bind lwc_enc80 lwc_enc80_chk #(.BLOCK_W(BLOCK_W), .ROUNDS(ROUNDS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .phase(phase), .rnd(rnd), .ct(ct), .done(done)
);

// File: tb/sim_lwc_enc80.sv
`timescale 1ns/1ps
module sim_lwc_enc80;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [63:0] pt = '0;
  logic [79:0] key = '0;
  logic [63:0] ct;
  logic        done;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  lwc_enc80 u0 (.clk(clk), .rst(rst), .start(start), .pt(pt), .key(key), .ct(ct), .done(done));

  // pt, key, expected
  localparam logic [207:0] VEC [4] = '{
    {64'h0000000000000000, 80'h00000000000000000000, 64'h5579C1387B228445},
    {64'h0000000000000000, 80'hFFFFFFFFFFFFFFFFFFFF, 64'hE72C46C0F5945049},
    {64'hFFFFFFFFFFFFFFFF, 80'h00000000000000000000, 64'hA112FFC72F68417B},
    {64'hFFFFFFFFFFFFFFFF, 80'hFFFFFFFFFFFFFFFFFFFF, 64'h3333DCD3213210D2}
  };

  localparam logic [3:0] BOX [16] = '{4'hC,4'h5,4'h6,4'hB,4'h9,4'h0,4'hA,4'hD,
                                      4'h3,4'hE,4'hF,4'h8,4'h4,4'h7,4'h1,4'h2};

  function automatic logic [63:0] model(input logic [63:0] p, input logic [79:0] k);
    logic [63:0] s, t;
    logic [79:0] kk;
    s = p; kk = k;
    for (int r = 1; r <= 31; r++) begin
      s = s ^ kk[79:16];
      for (int j = 0; j < 16; j++) t[4*j +: 4] = BOX[s[4*j +: 4]];
      for (int i = 0; i < 63; i++) s[(16*i) % 63] = t[i];
      s[63] = t[63];
      kk = {kk[18:0], kk[79:19]};
      kk[79:76] = BOX[kk[79:76]];
      kk[19:15] = kk[19:15] ^ 5'(r);
    end
    return s ^ kk[79:16];
  endfunction

  task automatic check(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [63:0] res;
  int          lat;

  // start a block, scramble inputs right after acceptance, wait for done
  task automatic run(input logic [63:0] p, input logic [79:0] k, input int busy_at,
                     input logic [63:0] p2);
    @(negedge clk);
    pt = p; key = k; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0; pt = ~p; key = ~k;          // R9 scramble
    lat = -1;
    for (int c = 1; c <= 100; c++) begin
      if (c == busy_at) begin start = 1'b1; pt = p2; end
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      if (done) begin lat = c; break; end
    end
    res = ct;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(ct == '0, "R10 reset ct", 80'(ct), 80'h0);
    check(done == 1'b0, "R10 reset done", 80'(done), 80'h0);

    // known-answer table (R1, R2, R3, R4, R5, R9)
    for (int v = 0; v < 4; v++) begin
      run(VEC[v][207:144], VEC[v][143:64], 0, '0);
      check(res == VEC[v][63:0], "R1 known answer", 80'(res), 80'(VEC[v][63:0]));
      check(lat == 32, "R5 latency", 80'(lat), 80'd32);
    end

    // further patterns against the bench model (R2 R3 R4)
    run(64'h0123456789ABCDEF, 80'h0011223344556677_8899, 0, '0);
    check(res == model(64'h0123456789ABCDEF, 80'h0011223344556677_8899),
          "R4 key schedule pattern", 80'(res), 80'(model(64'h0123456789ABCDEF, 80'h0011223344556677_8899)));
    run(64'h8000000000000001, 80'h80000000000000000001, 0, '0);
    check(res == model(64'h8000000000000001, 80'h80000000000000000001),
          "R3 edge bits", 80'(res), 80'(model(64'h8000000000000001, 80'h80000000000000000001)));

    // R6 pulse width and R7 hold
    @(negedge clk);
    check(done == 1'b0, "R6 pulse width", 80'(done), 80'h0);
    repeat (5) @(negedge clk);
    check(ct == res, "R7 ct hold", 80'(ct), 80'(res));

    // R8 start while busy
    run(64'hDEADBEEFCAFEF00D, 80'hA5A5A5A5A5A5A5A5A5A5, 6, 64'h1111111111111111);
    check(res == model(64'hDEADBEEFCAFEF00D, 80'hA5A5A5A5A5A5A5A5A5A5),
          "R8 busy start result", 80'(res), 80'(model(64'hDEADBEEFCAFEF00D, 80'hA5A5A5A5A5A5A5A5A5A5)));
    check(lat == 32, "R8 busy start latency", 80'(lat), 80'd32);
    @(negedge clk);
    check(done == 1'b0, "R8 no second block", 80'(done), 80'h0);

    // R10 reset mid-run
    @(negedge clk);
    pt = 64'h0F0F0F0F0F0F0F0F; key = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    begin
      int seen = 0;
      for (int c = 0; c < 60; c++) begin
        @(negedge clk);
        if (done) seen++;
      end
      check(seen == 0, "R10 abandoned block", 80'(seen), 80'h0);
    end
    check(ct == '0, "R10 ct cleared", 80'(ct), 80'h0);

    // recovery after reset
    run(VEC[0][207:144], VEC[0][143:64], 0, '0);
    check(res == VEC[0][63:0], "R1 after reset", 80'(res), 80'(VEC[0][63:0]));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule